// File: doc/BRIEF.md
# Segment Register Address Translator

This block converts a logical address, made of a segment register number and a 32-bit offset, into a 32-bit linear address. It keeps six segment registers. Each one carries a hidden cache of the descriptor it was loaded from. When software loads a selector, the block fetches the matching 8-byte descriptor with two 32-bit reads. The reads go to either the global or the local descriptor table, through a simple read port. The block then decodes the descriptor into the cache. After that, translations use only the cached copy and never touch the tables again.

Each translation adds the cached base to the offset. It checks the last byte of the access against the cached limit. It also checks a write against the segment type. A faulting access is reported with a fault code in place of a usable address. A load is checked too: it is rejected when it names a descriptor that is absent, a system descriptor, or one with too little privilege. A rejected load leaves the register unchanged.

Top module: `seg_xlate`

## Requirements
- R1: After reset every segment register is empty. Any translation through an empty register reports fault code 3. After reset `seg_busy` is 0, `ld_ready` is 1 and `mem_req` is 0.
- R2: The descriptor is located by selector bit 2: 0 selects `gdt_base` and 1 selects `ldt_base`. Its address is that base plus the index (selector bits 15:3) times 8. The block reads the low dword at that address first, then the high dword at address + 4.
- R3: While a load is in progress, `seg_busy` shows a single 1 at the target register and no other bit. `xl_ready` is low for a translation through that register and high for the other registers. `seg_busy` returns to 0 in the same cycle that `ld_done` pulses.
- R4: A successful translation returns base + offset, wrapping at 32 bits. The 32-bit base is assembled from three descriptor fields, from high to low: high-dword bits 31:24, high-dword bits 7:0, and low-dword bits 31:16.
- R5: The 20-bit limit is made of high-dword bits 19:16 above low-dword bits 15:0. An access of `xl_len` bytes (1 to 4) reports fault code 1 when offset + `xl_len` - 1 exceeds the limit. An access that ends exactly at the limit passes.
- R6: When granularity (high-dword bit 23) is 1, the limit is the 20-bit field shifted left by 12, with the low 12 bits set to ones.
- R7: A write reports fault code 2 in two cases: the segment is code (high-dword bit 11 is 1), or the segment is data whose writable bit (high-dword bit 9) is 0. A read from either kind of segment is allowed.
- R8: A null selector has index 0 and bit 2 equal to 0, whatever its low two bits. Loading it into register 0 (code) or 1 (stack) raises `ld_fault` and leaves the register unchanged. Loading it into registers 2 to 5 succeeds and empties the register. Register numbers 6 and 7 behave as empty registers.
- R9: A load raises `ld_fault` and leaves the register unchanged in three cases: the present bit (high-dword bit 15) is 0, the descriptor-type bit (high-dword bit 12) is 0, or the descriptor privilege (high-dword bits 14:13) is numerically below the larger of `cur_pl` and the selector's requested level (bits 1:0).
- R10: When several faults apply to one access, the fault code follows a fixed priority: empty register (3) first, then type (2), then limit (1).
- R11: A translation accepted on a clock edge, meaning `xl_valid` and `xl_ready` are both high, shows `xl_done` together with its result for exactly one cycle after that edge. `xl_fault` is high only together with `xl_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pl | input | 2 | Current privilege level used for load checks |
| gdt_base | input | 32 | Base address of the global descriptor table |
| ldt_base | input | 32 | Base address of the local descriptor table |
| ld_valid | input | 1 | Load request |
| ld_reg | input | 3 | Segment register to load (0 code, 1 stack, 2-5 data) |
| ld_sel | input | 16 | Selector to load |
| ld_ready | output | 1 | Loader idle, request accepted |
| ld_done | output | 1 | One-cycle pulse when a load finishes |
| ld_fault | output | 1 | With ld_done: load rejected |
| seg_busy | output | 6 | Per-register fetch in progress |
| mem_req | output | 1 | Table read request, held until mem_rvalid |
| mem_addr | output | 32 | Table read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| xl_valid | input | 1 | Translation request |
| xl_reg | input | 3 | Segment register used |
| xl_off | input | 32 | Offset |
| xl_len | input | 3 | Access size in bytes, 1 to 4 |
| xl_write | input | 1 | Access is a write |
| xl_ready | output | 1 | Translation can be accepted |
| xl_done | output | 1 | Result valid |
| xl_lin | output | 32 | Linear address |
| xl_fault | output | 1 | Access faulted |
| xl_code | output | 2 | Fault code: 1 limit, 2 type, 3 empty register |

## Verification
Some properties are checked on every cycle. The busy vector never marks more than one register, and it is clear whenever a load finishes. A table read is only requested while a register is busy. The second read of a fetch always addresses four bytes above the first. A result appears only one cycle after an accepted request, and a fault only appears alongside a result. Other behaviour only the bench scenarios can show. These are the decoded base, the limit and granularity edges, the type and privilege rules, the fault priority, and the handling of null selectors. The bench also shows that a translation through a busy register waits until the new descriptor is in place.

// File: rtl/segx_pkg.sv
package segx_pkg;
    localparam int AW = 32;

    // Fault codes reported with a translation result
    localparam logic [1:0] FLT_NONE  = 2'd0;
    localparam logic [1:0] FLT_LIMIT = 2'd1;
    localparam logic [1:0] FLT_TYPE  = 2'd2;
    localparam logic [1:0] FLT_EMPTY = 2'd3;

    // Decoded descriptor as held in a segment register's hidden cache
    typedef struct packed {
        logic          valid;
        logic [AW-1:0] base;
        logic [AW-1:0] limit;
        logic          code;
        logic          wr;
    } seg_ent_t;

    typedef enum logic [1:0] {LS_IDLE, LS_LO, LS_HI} ld_st_e;
endpackage

// File: rtl/segx_loader.sv
module segx_loader
    import segx_pkg::*;
#(
    parameter int NSEG = 6,
    localparam int RW = $clog2(NSEG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      cur_pl,
    input  logic [AW-1:0]   gdt_base,
    input  logic [AW-1:0]   ldt_base,
    input  logic            ld_valid,
    input  logic [RW-1:0]   ld_reg,
    input  logic [15:0]     ld_sel,
    output logic            ld_ready,
    output logic            ld_done,
    output logic            ld_fault,
    output logic [NSEG-1:0] busy_vec,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_rvalid,
    input  logic [31:0]     mem_rdata,
    output logic            wr_en,
    output logic [RW-1:0]   wr_idx,
    output seg_ent_t        wr_ent
);
    typedef struct packed {
        ld_st_e        st;
        logic [RW-1:0] tgt;
        logic [1:0]    epl;
        logic [AW-1:0] addr;
        logic [31:0]   lo;
        logic          done;
        logic          fault;
    } ld_s_t;

    ld_s_t s_d, s_q;
    logic [19:0] lim20;
    logic        sel_null;
    logic        acc_ok;

    always_comb begin
        s_d      = s_q;
        s_d.done  = 1'b0;
        s_d.fault = 1'b0;
        wr_en    = 1'b0;
        wr_idx   = s_q.tgt;
        wr_ent   = '0;
        sel_null = (ld_sel[15:3] == 13'd0) && !ld_sel[2];
        lim20    = {mem_rdata[19:16], s_q.lo[15:0]};
        acc_ok   = mem_rdata[15] && mem_rdata[12] && (mem_rdata[14:13] >= s_q.epl);
        unique case (s_q.st)
            LS_IDLE: if (ld_valid) begin
                if (sel_null || ld_reg >= RW'(NSEG)) begin
                    s_d.done = 1'b1;
                    if (ld_reg < RW'(2) || ld_reg >= RW'(NSEG)) begin
                        s_d.fault = 1'b1;
                    end else begin
                        wr_en  = 1'b1;
                        wr_idx = ld_reg;
                    end
                end else begin
                    s_d.st   = LS_LO;
                    s_d.tgt  = ld_reg;
                    s_d.epl  = (cur_pl > ld_sel[1:0]) ? cur_pl : ld_sel[1:0];
                    s_d.addr = (ld_sel[2] ? ldt_base : gdt_base)
                             + {{(AW-16){1'b0}}, ld_sel[15:3], 3'b000};
                end
            end
            LS_LO: if (mem_rvalid) begin
                s_d.lo   = mem_rdata;
                s_d.addr = s_q.addr + AW'(4);
                s_d.st   = LS_HI;
            end
            LS_HI: if (mem_rvalid) begin
                s_d.st   = LS_IDLE;
                s_d.done = 1'b1;
                if (acc_ok) begin
                    wr_en        = 1'b1;
                    wr_ent.valid = 1'b1;
                    wr_ent.base  = {mem_rdata[31:24], mem_rdata[7:0], s_q.lo[31:16]};
                    wr_ent.limit = mem_rdata[23] ? {lim20, 12'hFFF} : {12'h000, lim20};
                    wr_ent.code  = mem_rdata[11];
                    wr_ent.wr    = mem_rdata[9] && !mem_rdata[11];
                end else begin
                    s_d.fault = 1'b1;
                end
            end
            default: s_d.st = LS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: LS_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        busy_vec = '0;
        if (s_q.st != LS_IDLE) busy_vec[s_q.tgt] = 1'b1;
    end

    assign ld_ready = (s_q.st == LS_IDLE);
    assign mem_req  = (s_q.st != LS_IDLE);
    assign mem_addr = s_q.addr;
    assign ld_done  = s_q.done;
    assign ld_fault = s_q.fault;
endmodule

// File: rtl/segx_cache.sv
module segx_cache
    import segx_pkg::*;
#(
    parameter int NSEG = 6,
    localparam int RW = $clog2(NSEG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_idx,
    input  seg_ent_t      wr_ent,
    input  logic [RW-1:0] rd_idx,
    output seg_ent_t      rd_ent
);
    seg_ent_t ent_d [NSEG];
    seg_ent_t ent_q [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_ent
        always_comb begin
            ent_d[g] = ent_q[g];
            if (wr_en && wr_idx == RW'(g)) ent_d[g] = wr_ent;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) ent_q[g] <= '0;
            else        ent_q[g] <= ent_d[g];
        end
    end

    // Register numbers outside the bank read as empty
    always_comb begin
        rd_ent = '0;
        for (int i = 0; i < NSEG; i++) begin
            if (rd_idx == RW'(i)) rd_ent = ent_q[i];
        end
    end
endmodule

// File: rtl/segx_check.sv
module segx_check
    import segx_pkg::*;
(
    input  seg_ent_t      ent,
    input  logic [AW-1:0] off,
    input  logic [2:0]    len,
    input  logic          write,
    output logic [AW-1:0] lin,
    output logic          fault,
    output logic [1:0]    code
);
    logic [AW:0] last_byte;

    always_comb begin
        last_byte = {1'b0, off} + (AW+1)'(len) - (AW+1)'(1);
        lin       = ent.base + off;
        if (!ent.valid)                   code = FLT_EMPTY;
        else if (write && !ent.wr)        code = FLT_TYPE;
        else if (last_byte > {1'b0, ent.limit}) code = FLT_LIMIT;
        else                              code = FLT_NONE;
        fault = (code != FLT_NONE);
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import segx_pkg::*;
#(
    parameter int NSEG = 6,
    localparam int RW = $clog2(NSEG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      cur_pl,
    input  logic [31:0]     gdt_base,
    input  logic [31:0]     ldt_base,
    input  logic            ld_valid,
    input  logic [RW-1:0]   ld_reg,
    input  logic [15:0]     ld_sel,
    output logic            ld_ready,
    output logic            ld_done,
    output logic            ld_fault,
    output logic [NSEG-1:0] seg_busy,
    output logic            mem_req,
    output logic [31:0]     mem_addr,
    input  logic            mem_rvalid,
    input  logic [31:0]     mem_rdata,
    input  logic            xl_valid,
    input  logic [RW-1:0]   xl_reg,
    input  logic [31:0]     xl_off,
    input  logic [2:0]      xl_len,
    input  logic            xl_write,
    output logic            xl_ready,
    output logic            xl_done,
    output logic [31:0]     xl_lin,
    output logic            xl_fault,
    output logic [1:0]      xl_code
);
    typedef struct packed {
        logic          done;
        logic          fault;
        logic [1:0]    code;
        logic [AW-1:0] lin;
    } xo_t;

    logic          wr_en;
    logic [RW-1:0] wr_idx;
    seg_ent_t      wr_ent;
    seg_ent_t      rd_ent;
    logic [AW-1:0] c_lin;
    logic          c_fault;
    logic [1:0]    c_code;
    xo_t           o_d, o_q;

    segx_loader #(.NSEG(NSEG)) u_loader (
        .clk(clk), .rst_n(rst_n), .cur_pl(cur_pl),
        .gdt_base(gdt_base), .ldt_base(ldt_base),
        .ld_valid(ld_valid), .ld_reg(ld_reg), .ld_sel(ld_sel),
        .ld_ready(ld_ready), .ld_done(ld_done), .ld_fault(ld_fault),
        .busy_vec(seg_busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_ent(wr_ent)
    );

    segx_cache #(.NSEG(NSEG)) u_cache (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_ent(wr_ent), .rd_idx(xl_reg), .rd_ent(rd_ent)
    );

    segx_check u_check (
        .ent(rd_ent), .off(xl_off), .len(xl_len), .write(xl_write),
        .lin(c_lin), .fault(c_fault), .code(c_code)
    );

    always_comb begin
        xl_ready = 1'b1;
        for (int i = 0; i < NSEG; i++) begin
            if (xl_reg == RW'(i) && seg_busy[i]) xl_ready = 1'b0;
        end
    end

    always_comb begin
        o_d       = o_q;
        o_d.done  = xl_valid && xl_ready;
        o_d.fault = 1'b0;
        if (xl_valid && xl_ready) begin
            o_d.fault = c_fault;
            o_d.code  = c_code;
            o_d.lin   = c_lin;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign xl_done  = o_q.done;
    assign xl_fault = o_q.fault;
    assign xl_code  = o_q.code;
    assign xl_lin   = o_q.lin;
endmodule

// File: rtl/seg_xlate_sva.sv
module seg_xlate_sva #(
    parameter int NSEG = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_req,
    input logic            mem_rvalid,
    input logic [31:0]     mem_addr,
    input logic [NSEG-1:0] seg_busy,
    input logic            ld_done,
    input logic            xl_valid,
    input logic            xl_ready,
    input logic            xl_done,
    input logic            xl_fault
);
    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (seg_busy != '0)); // R3
    AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(seg_busy)); // R3
    AST_BUSY_FREE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done |-> (seg_busy == '0)); // R3
    AST_HI_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req && mem_rvalid)) |-> (mem_addr == $past(mem_addr) + 32'd4)); // R2
    AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        xl_done |-> $past(xl_valid && xl_ready)); // R11
    AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        xl_fault |-> xl_done); // R11
endmodule

bind seg_xlate seg_xlate_sva #(.NSEG(NSEG)) u_sva (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_rvalid(mem_rvalid),
    .mem_addr(mem_addr), .seg_busy(seg_busy), .ld_done(ld_done),
    .xl_valid(xl_valid), .xl_ready(xl_ready), .xl_done(xl_done),
    .xl_fault(xl_fault)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cur_pl = 2'd3;
    logic [31:0] gdt_base = 32'h0;
    logic [31:0] ldt_base = 32'h80;
    logic        ld_valid = 1'b0;
    logic [2:0]  ld_reg = '0;
    logic [15:0] ld_sel = '0;
    logic        ld_ready, ld_done, ld_fault;
    logic [5:0]  seg_busy;
    logic        mem_req, mem_rvalid;
    logic [31:0] mem_addr, mem_rdata;
    logic        xl_valid = 1'b0;
    logic [2:0]  xl_reg = '0;
    logic [31:0] xl_off = '0;
    logic [2:0]  xl_len = 3'd1;
    logic        xl_write = 1'b0;
    logic        xl_ready, xl_done, xl_fault;
    logic [31:0] xl_lin;
    logic [1:0]  xl_code;

    logic [31:0] memw [64];
    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    assign mem_rvalid = mem_req;
    assign mem_rdata  = memw[mem_addr[7:2]];

    seg_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .cur_pl(cur_pl), .gdt_base(gdt_base),
        .ldt_base(ldt_base), .ld_valid(ld_valid), .ld_reg(ld_reg),
        .ld_sel(ld_sel), .ld_ready(ld_ready), .ld_done(ld_done),
        .ld_fault(ld_fault), .seg_busy(seg_busy), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .xl_valid(xl_valid), .xl_reg(xl_reg), .xl_off(xl_off),
        .xl_len(xl_len), .xl_write(xl_write), .xl_ready(xl_ready),
        .xl_done(xl_done), .xl_lin(xl_lin), .xl_fault(xl_fault),
        .xl_code(xl_code)
    );

    typedef struct packed {
        logic [2:0]  r;
        logic [31:0] off;
        logic [2:0]  len;
        logic        wr;
        logic [1:0]  code;
        logic [31:0] lin;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VT [NV] = '{
        '{3'd2, 32'h0000_0010, 3'd4, 1'b0, 2'd0, 32'h1000_0010}, // R4
        '{3'd2, 32'h0000_0FFC, 3'd4, 1'b1, 2'd0, 32'h1000_0FFC}, // R5 ends at limit
        '{3'd2, 32'h0000_0FFD, 3'd4, 1'b0, 2'd1, 32'h0},         // R5 one past
        '{3'd2, 32'h0000_0FFF, 3'd1, 1'b0, 2'd0, 32'h1000_0FFF}, // R5
        '{3'd0, 32'h0000_0100, 3'd4, 1'b0, 2'd0, 32'h0040_0100}, // R7 code read
        '{3'd0, 32'h0000_0100, 3'd4, 1'b1, 2'd2, 32'h0},         // R7 code write
        '{3'd3, 32'h0000_0000, 3'd1, 1'b1, 2'd2, 32'h0},         // R7 read-only write
        '{3'd3, 32'h0000_0010, 3'd1, 1'b0, 2'd0, 32'h2000_0010}, // R7 read-only read
        '{3'd3, 32'h0000_0020, 3'd4, 1'b1, 2'd2, 32'h0},         // R10 type over limit
        '{3'd4, 32'h0000_2FFC, 3'd4, 1'b0, 2'd0, 32'h3000_2FFC}, // R6
        '{3'd4, 32'h0000_2FFD, 3'd4, 1'b0, 2'd1, 32'h0},         // R6
        '{3'd5, 32'h0000_00FF, 3'd1, 1'b0, 2'd0, 32'h4000_00FF}, // R4 local table
        '{3'd1, 32'h0000_0020, 3'd2, 1'b1, 2'd0, 32'h1000_0020}, // R4 stack
        '{3'd6, 32'h0000_0000, 3'd1, 1'b0, 2'd3, 32'h0}          // R8 reg 6 empty
    };

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic put_desc(input int w, input logic [31:0] base, input logic [19:0] lim,
                            input logic g, input logic [3:0] typ, input logic [1:0] dpl,
                            input logic p);
        memw[w]   = {base[15:0], lim[15:0]};
        memw[w+1] = {base[31:24], g, 3'b100, lim[19:16], p, dpl, 1'b1, typ, base[23:16]};
    endtask

    task automatic do_load(input logic [2:0] r, input logic [15:0] s, output logic f,
                           output logic [31:0] a0, output logic [31:0] a1);
        int n = 0;
        a0 = '0; a1 = '0;
        while (!ld_ready) @(negedge clk);
        ld_valid = 1'b1; ld_reg = r; ld_sel = s;
        @(negedge clk);
        ld_valid = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (ld_done) break;
            if (mem_req) begin
                if (n == 0) a0 = mem_addr; else a1 = mem_addr;
                n++;
            end
            @(negedge clk);
        end
        f = ld_fault;
    endtask

    task automatic do_xl(input logic [2:0] r, input logic [31:0] off, input logic [2:0] len,
                         input logic wr, output logic dn, output logic [1:0] code,
                         output logic [31:0] lin);
        xl_valid = 1'b1; xl_reg = r; xl_off = off; xl_len = len; xl_write = wr;
        @(negedge clk);
        xl_valid = 1'b0;
        dn = xl_done; code = xl_fault ? xl_code : 2'd0; lin = xl_lin;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic f, dn;
        logic [31:0] a0, a1, lin;
        logic [1:0]  code;
        for (int i = 0; i < 64; i++) memw[i] = '0;
        put_desc(2,  32'h1000_0000, 20'h00FFF, 1'b0, 4'b0010, 2'd3, 1'b1);
        put_desc(4,  32'h0040_0000, 20'h0FFFF, 1'b0, 4'b1010, 2'd3, 1'b1);
        put_desc(6,  32'h2000_0000, 20'h00010, 1'b0, 4'b0000, 2'd3, 1'b1);
        put_desc(8,  32'h3000_0000, 20'h00002, 1'b1, 4'b0010, 2'd3, 1'b1);
        put_desc(10, 32'h5000_0000, 20'h0FFFF, 1'b0, 4'b0010, 2'd0, 1'b1);
        put_desc(12, 32'h6000_0000, 20'h0FFFF, 1'b0, 4'b0010, 2'd3, 1'b0);
        put_desc(34, 32'h4000_0000, 20'h000FF, 1'b0, 4'b0010, 2'd3, 1'b1);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "seg_busy", 32'(seg_busy), 32'h0);
        chk("R1", "ld_ready", 32'(ld_ready), 32'h1);
        chk("R1", "mem_req", 32'(mem_req), 32'h0);
        do_xl(3'd2, 32'h10, 3'd1, 1'b0, dn, code, lin);
        chk("R1", "empty DS code", 32'(code), 32'd3);
        do_xl(3'd0, 32'h10, 3'd1, 1'b0, dn, code, lin);
        chk("R1", "empty CS code", 32'(code), 32'd3);

        do_load(3'd0, 16'h0013, f, a0, a1); chk("R9", "CS load fault", 32'(f), 32'h0);
        do_load(3'd1, 16'h000B, f, a0, a1); chk("R9", "SS load fault", 32'(f), 32'h0);
        do_load(3'd2, 16'h000B, f, a0, a1); chk("R9", "DS load fault", 32'(f), 32'h0);
        do_load(3'd3, 16'h001B, f, a0, a1);
        chk("R2", "ES low addr", a0, 32'h18);
        chk("R2", "ES high addr", a1, 32'h1C);
        do_load(3'd4, 16'h0023, f, a0, a1); chk("R6", "FS load fault", 32'(f), 32'h0);
        do_load(3'd5, 16'h000F, f, a0, a1);
        chk("R2", "GS local low addr", a0, 32'h88);
        chk("R2", "GS local high addr", a1, 32'h8C);

        for (int i = 0; i < NV; i++) begin
            do_xl(VT[i].r, VT[i].off, VT[i].len, VT[i].wr, dn, code, lin);
            chk("R11", $sformatf("vec %0d done", i), 32'(dn), 32'h1);
            chk("R4-R10", $sformatf("vec %0d code", i), 32'(code), 32'(VT[i].code));
            if (VT[i].code == 2'd0) chk("R4", $sformatf("vec %0d lin", i), lin, VT[i].lin);
        end

        // R11 single-cycle result
        do_xl(3'd2, 32'h0, 3'd1, 1'b0, dn, code, lin);
        @(negedge clk);
        chk("R11", "done drops", 32'(xl_done), 32'h0);

        // R3 stall during a fetch into register 4
        ld_valid = 1'b1; ld_reg = 3'd4; ld_sel = 16'h0023;
        @(negedge clk);
        ld_valid = 1'b0;
        chk("R3", "busy vec", 32'(seg_busy), 32'h10);
        xl_reg = 3'd2;
        #1 chk("R3", "other reg ready", 32'(xl_ready), 32'h1);
        xl_valid = 1'b1; xl_reg = 3'd4; xl_off = 32'h10; xl_len = 3'd1; xl_write = 1'b0;
        #1 chk("R3", "busy reg stalled", 32'(xl_ready), 32'h0);
        @(negedge clk);
        chk("R3", "no result while busy", 32'(xl_done), 32'h0);
        @(negedge clk);
        chk("R3", "busy cleared", 32'(seg_busy), 32'h0);
        chk("R3", "load done", 32'(ld_done), 32'h1);
        @(negedge clk);
        xl_valid = 1'b0;
        chk("R3", "stalled xlate done", 32'(xl_done), 32'h1);
        chk("R3", "stalled xlate lin", xl_lin, 32'h3000_0010);

        // R8 null selectors
        do_load(3'd1, 16'h0000, f, a0, a1);
        chk("R8", "null into SS fault", 32'(f), 32'h1);
        do_xl(3'd1, 32'h20, 3'd2, 1'b1, dn, code, lin);
        chk("R8", "SS kept code", 32'(code), 32'd0);
        chk("R8", "SS kept lin", lin, 32'h1000_0020);
        do_load(3'd0, 16'h0003, f, a0, a1);
        chk("R8", "null into CS fault", 32'(f), 32'h1);
        do_load(3'd2, 16'h0003, f, a0, a1);
        chk("R8", "null into DS ok", 32'(f), 32'h0);
        do_xl(3'd2, 32'h0, 3'd1, 1'b0, dn, code, lin);
        chk("R8", "null DS access", 32'(code), 32'd3);
        do_xl(3'd2, 32'hFFFF_FFFF, 3'd4, 1'b1, dn, code, lin);
        chk("R10", "null over type and limit", 32'(code), 32'd3);

        // R9 load checks on register 3
        do_load(3'd3, 16'h002B, f, a0, a1);
        chk("R9", "privilege fault", 32'(f), 32'h1);
        do_load(3'd3, 16'h0033, f, a0, a1);
        chk("R9", "not present fault", 32'(f), 32'h1);
        do_xl(3'd3, 32'h10, 3'd1, 1'b0, dn, code, lin);
        chk("R9", "ES unchanged lin", lin, 32'h2000_0010);
        cur_pl = 2'd0;
        do_load(3'd3, 16'h002B, f, a0, a1);
        chk("R9", "requested level fault", 32'(f), 32'h1);
        do_load(3'd3, 16'h0028, f, a0, a1);
        chk("R9", "privileged load ok", 32'(f), 32'h0);
        do_xl(3'd3, 32'h4, 3'd4, 1'b1, dn, code, lin);
        chk("R9", "new ES code", 32'(code), 32'd0);
        chk("R9", "new ES lin", lin, 32'h5000_0004);
        chk("R1", "mem idle", 32'(mem_req), 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule